// File: doc/BRIEF.md
# Character-Mode Video Timing Generator

This block drives a text-only raster display of 40 columns by 25 rows from a single 16 MHz master clock. A 10-bit horizontal counter runs for 1024 master clocks per line, which is 64 µs. A line counter runs through a 312-line non-interlaced frame, about 50.08 Hz. Together they produce active-low horizontal and vertical sync, active-high horizontal and vertical blanking, and a one-cycle enable every 16 master clocks that paces the 1 MHz system processor. The vertical blanking output also serves as a status flag. Software polls it so that it writes screen memory only while nothing is being drawn.

While a character row is on screen, the block fetches one character every 16 master clocks. It puts a screen-memory address (row × 40 + column) on its port. It latches the character code that comes back, then forms a pattern-memory address from that code and the scan line within the row. The returned 8-bit pattern goes into a shift register. That register sends one pixel out every two master clocks, most significant bit first. Both memories are external, and each returns data one clock after it receives an address. The pattern memory is wired only to this block.

Top module: `video_timing_gen`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, every counter is zero (horizontal position h = 0, line 0). In that state: cpuClkEn = 1, hBlank = 1, vBlank = 0, hSyncN = 1, vSyncN = 1, pixel = 0 and screenAddr = 0.
- R2: cpuClkEn is high in exactly the cycles where h mod 16 = 0, so there is one pulse every 16 master clocks.
- R3: A line lasts 1024 clocks (h = 0 to 1023). hBlank is low exactly for 192 ≤ h < 832, which is 640 clocks or 320 pixels.
- R4: hSyncN is low exactly for 880 ≤ h < 955, which is 75 clocks.
- R5: A frame lasts LINES_PER_FRAME lines (default 312). vBlank is high exactly on lines ≥ 8 × ROWS (default 200).
- R6: vSyncN is low for 3 lines starting at line VSYNC_FIRST (default 250).
- R7: On visible lines, for 176 ≤ h < 816, screenAddr = (line / 8) × 40 + (h − 176) / 16. In all other cycles screenAddr is 0.
- R8: In the same window, from slot phase (h − 176) mod 16 = 2 through 15, romAddr = {charCode returned for that slot's screenAddr, line mod 8}. The code occupies the upper 8 bits and the scan line the lower 3 bits.
- R9: For 192 ≤ h < 832 on visible lines, let x = (h − 192) / 2. Then pixel equals bit 7 − (x mod 8) of the pattern stored for the character at column x / 8 and the current scan line.
- R10: Whenever hBlank or vBlank is high, pixel is 0.
- R11: A reset applied in the middle of a frame restarts the raster at line 0, clock 0, and the following fetches begin again at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| charCode | input | 8 | Screen-memory data, valid one clock after screenAddr |
| romData | input | 8 | Pattern-memory data, valid one clock after romAddr |
| cpuClkEn | output | 1 | One-cycle system clock enable, every 16 clocks |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSyncN | output | 1 | Vertical sync, active low |
| hBlank | output | 1 | Horizontal blanking, active high |
| vBlank | output | 1 | Vertical blanking, also polled as the CPU sync flag |
| screenAddr | output | 10 | Screen-memory address (0 to 999) |
| romAddr | output | 11 | Pattern-memory address {code, scan line} |
| pixel | output | 1 | Serial pixel, forced to 0 while blanking |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that the horizontal parameters keep their default values, because the checker takes its pulse widths from the top's parameters. The pixel and address checks further assume that both memories answer exactly one clock after the address they are given. The bench keeps to this by modelling both memories as registered lookups of randomly filled arrays. To keep whole frames within the run length, the bench shortens the frame to 40 lines, with 3 character rows and vertical sync at line 30. It applies one reset at a random point partway through the first frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  // Strobes decoded by the control from the raster position
  typedef struct packed {
    logic lineEnd;     // last clock of a line
    logic frameEnd;    // last line of the frame
    logic rowAdvance;  // move row base to the next character row
    logic fetchWin;    // screen address is being presented
    logic colStep;     // end of a fetch slot
    logic latchCode;   // capture the returned character code
    logic loadShift;   // load the returned pattern into the shifter
    logic shiftStep;   // advance the shifter by one pixel
    logic visible;     // inside the active picture
  } vtgStrobes_t;

endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int LINE_CLKS       = 1024,
  parameter int LINES_PER_FRAME = 312,
  parameter int COLS            = 40,
  parameter int ROWS            = 25,
  parameter int CHAR_W          = 8,
  parameter int CHAR_H          = 8,
  parameter int PIX_CLKS        = 2,
  parameter int H_DISP_START    = 192,
  parameter int HSYNC_START     = 880,
  parameter int HSYNC_CLKS      = 75,
  parameter int VSYNC_FIRST     = 250,
  parameter int VSYNC_LINES     = 3,
  parameter int CLK_DIV         = 16,
  localparam int HB = $clog2(LINE_CLKS),
  localparam int VB = $clog2(LINES_PER_FRAME)
) (
  input  logic [HB-1:0] hCount,
  input  logic [VB-1:0] vCount,
  output vtgStrobes_t   strb,
  output logic          hBlank,
  output logic          vBlank,
  output logic          hSyncN,
  output logic          vSyncN,
  output logic          cpuClkEn
);

  localparam int SLOT       = CHAR_W * PIX_CLKS;
  localparam int SLOT_BITS  = $clog2(SLOT);
  localparam int PIX_BITS   = (PIX_CLKS > 1) ? $clog2(PIX_CLKS) : 1;
  localparam int DIV_BITS   = $clog2(CLK_DIV);
  localparam int SCAN_BITS  = $clog2(CHAR_H);
  localparam int ACT_LINES  = ROWS * CHAR_H;
  localparam int H_DISP_END = H_DISP_START + COLS * SLOT;

  localparam logic [HB-1:0] H_LAST     = HB'(LINE_CLKS - 1);
  localparam logic [HB-1:0] H_DISP_LO  = HB'(H_DISP_START);
  localparam logic [HB-1:0] H_DISP_HI  = HB'(H_DISP_END);
  localparam logic [HB-1:0] H_FETCH_LO = HB'(H_DISP_START - SLOT);
  localparam logic [HB-1:0] H_FETCH_HI = HB'(H_DISP_END - SLOT);
  localparam logic [HB-1:0] H_SYNC_LO  = HB'(HSYNC_START);
  localparam logic [HB-1:0] H_SYNC_HI  = HB'(HSYNC_START + HSYNC_CLKS);
  localparam logic [VB-1:0] V_LAST     = VB'(LINES_PER_FRAME - 1);
  localparam logic [VB-1:0] V_ACT      = VB'(ACT_LINES);
  localparam logic [VB-1:0] V_ACT_LAST = VB'(ACT_LINES - 1);
  localparam logic [VB-1:0] V_SYNC_LO  = VB'(VSYNC_FIRST);
  localparam logic [VB-1:0] V_SYNC_HI  = VB'(VSYNC_FIRST + VSYNC_LINES);

  logic activeLine;
  logic hDisp;
  logic slotEnd;
  logic pixEnd;
  logic [SLOT_BITS-1:0] phase;

  assign phase      = hCount[SLOT_BITS-1:0];
  assign activeLine = vCount < V_ACT;
  assign hDisp      = (hCount >= H_DISP_LO) && (hCount < H_DISP_HI);
  assign slotEnd    = phase == SLOT_BITS'(SLOT - 1);
  assign pixEnd     = (PIX_CLKS > 1) ? (phase[PIX_BITS-1:0] == {PIX_BITS{1'b1}}) : 1'b1;

  always_comb begin
    strb            = '0;
    strb.lineEnd    = hCount == H_LAST;
    strb.frameEnd   = vCount == V_LAST;
    strb.fetchWin   = activeLine && (hCount >= H_FETCH_LO) && (hCount < H_FETCH_HI);
    strb.colStep    = strb.fetchWin && slotEnd;
    strb.latchCode  = strb.fetchWin && (phase == SLOT_BITS'(1));
    strb.loadShift  = strb.colStep;
    strb.visible    = activeLine && hDisp;
    strb.shiftStep  = strb.visible && pixEnd && !strb.loadShift;
    strb.rowAdvance = strb.lineEnd && activeLine && (vCount != V_ACT_LAST) &&
                      (vCount[SCAN_BITS-1:0] == {SCAN_BITS{1'b1}});
  end

  assign hBlank   = !hDisp;
  assign vBlank   = !activeLine;
  assign hSyncN   = !((hCount >= H_SYNC_LO) && (hCount < H_SYNC_HI));
  assign vSyncN   = !((vCount >= V_SYNC_LO) && (vCount < V_SYNC_HI));
  assign cpuClkEn = hCount[DIV_BITS-1:0] == '0;

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int LINE_CLKS       = 1024,
  parameter int LINES_PER_FRAME = 312,
  parameter int COLS            = 40,
  parameter int ROWS            = 25,
  parameter int CHAR_W          = 8,
  parameter int CHAR_H          = 8,
  parameter int CODE_W          = 8,
  localparam int HB = $clog2(LINE_CLKS),
  localparam int VB = $clog2(LINES_PER_FRAME),
  localparam int AB = $clog2(COLS * ROWS),
  localparam int CB = $clog2(COLS),
  localparam int SB = $clog2(CHAR_H),
  localparam int RB = CODE_W + SB
) (
  input  logic              clk,
  input  logic              rst,
  input  vtgStrobes_t       strb,
  input  logic [CODE_W-1:0] charCode,
  input  logic [CHAR_W-1:0] romData,
  output logic [HB-1:0]     hCount,
  output logic [VB-1:0]     vCount,
  output logic [AB-1:0]     screenAddr,
  output logic [RB-1:0]     romAddr,
  output logic              pixel
);

  logic [AB-1:0]     rowBase;
  logic [CB-1:0]     fetchCol;
  logic [CODE_W-1:0] codeReg;
  logic [CHAR_W-1:0] shiftReg;

  // Raster position
  always_ff @(posedge clk) begin
    if (rst) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strb.lineEnd) begin
      hCount <= '0;
      vCount <= strb.frameEnd ? '0 : vCount + 1'b1;
    end else begin
      hCount <= hCount + 1'b1;
    end
  end

  // Running row base replaces a row x columns multiplier
  always_ff @(posedge clk) begin
    if (rst || (strb.lineEnd && strb.frameEnd)) rowBase <= '0;
    else if (strb.rowAdvance)                   rowBase <= rowBase + AB'(COLS);
  end

  always_ff @(posedge clk) begin
    if (rst || strb.lineEnd) fetchCol <= '0;
    else if (strb.colStep)   fetchCol <= fetchCol + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 codeReg <= '0;
    else if (strb.latchCode) codeReg <= charCode;
  end

  always_ff @(posedge clk) begin
    if (rst)                 shiftReg <= '0;
    else if (strb.loadShift) shiftReg <= romData;
    else if (strb.shiftStep) shiftReg <= {shiftReg[CHAR_W-2:0], 1'b0};
  end

  assign screenAddr = strb.fetchWin ? (rowBase + AB'(fetchCol)) : '0;
  assign romAddr    = {codeReg, vCount[SB-1:0]};
  assign pixel      = strb.visible & shiftReg[CHAR_W-1];

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int LINE_CLKS       = 1024,
  parameter int LINES_PER_FRAME = 312,
  parameter int COLS            = 40,
  parameter int ROWS            = 25,
  parameter int CHAR_W          = 8,
  parameter int CHAR_H          = 8,
  parameter int CODE_W          = 8,
  parameter int PIX_CLKS        = 2,
  parameter int H_DISP_START    = 192,
  parameter int HSYNC_START     = 880,
  parameter int HSYNC_CLKS      = 75,
  parameter int VSYNC_FIRST     = 250,
  parameter int VSYNC_LINES     = 3,
  parameter int CLK_DIV         = 16,
  localparam int HB = $clog2(LINE_CLKS),
  localparam int VB = $clog2(LINES_PER_FRAME),
  localparam int AB = $clog2(COLS * ROWS),
  localparam int RB = CODE_W + $clog2(CHAR_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] charCode,
  input  logic [CHAR_W-1:0] romData,
  output logic              cpuClkEn,
  output logic              hSyncN,
  output logic              vSyncN,
  output logic              hBlank,
  output logic              vBlank,
  output logic [AB-1:0]     screenAddr,
  output logic [RB-1:0]     romAddr,
  output logic              pixel
);

  vtgStrobes_t   strb;
  logic [HB-1:0] hCount;
  logic [VB-1:0] vCount;

  vtg_ctrl #(
    .LINE_CLKS(LINE_CLKS), .LINES_PER_FRAME(LINES_PER_FRAME),
    .COLS(COLS), .ROWS(ROWS), .CHAR_W(CHAR_W), .CHAR_H(CHAR_H),
    .PIX_CLKS(PIX_CLKS), .H_DISP_START(H_DISP_START),
    .HSYNC_START(HSYNC_START), .HSYNC_CLKS(HSYNC_CLKS),
    .VSYNC_FIRST(VSYNC_FIRST), .VSYNC_LINES(VSYNC_LINES), .CLK_DIV(CLK_DIV)
  ) uCtrl (
    .hCount(hCount), .vCount(vCount), .strb(strb),
    .hBlank(hBlank), .vBlank(vBlank), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .cpuClkEn(cpuClkEn)
  );

  vtg_datapath #(
    .LINE_CLKS(LINE_CLKS), .LINES_PER_FRAME(LINES_PER_FRAME),
    .COLS(COLS), .ROWS(ROWS), .CHAR_W(CHAR_W), .CHAR_H(CHAR_H), .CODE_W(CODE_W)
  ) uData (
    .clk(clk), .rst(rst), .strb(strb), .charCode(charCode), .romData(romData),
    .hCount(hCount), .vCount(vCount), .screenAddr(screenAddr),
    .romAddr(romAddr), .pixel(pixel)
  );

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int CLK_DIV    = 16,
  parameter int HSYNC_CLKS = 75,
  parameter int CELLS      = 1000,
  parameter int AB         = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cpuClkEn,
  input logic          hSyncN,
  input logic          vSyncN,
  input logic          hBlank,
  input logic          vBlank,
  input logic [AB-1:0] screenAddr,
  input logic          pixel
);

  logic [15:0] enGap;
  logic        enSeen;
  logic [15:0] syncLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      enGap  <= '0;
      enSeen <= 1'b0;
    end else if (cpuClkEn) begin
      enGap  <= '0;
      enSeen <= 1'b1;
    end else begin
      enGap <= enGap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hSyncN) syncLen <= '0;
    else               syncLen <= syncLen + 1'b1;
  end

  AST_CPU_EN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (cpuClkEn && enSeen) |-> (enGap == 16'(CLK_DIV - 1))); // R2

  AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(hSyncN) |-> (syncLen == 16'(HSYNC_CLKS))); // R4

  AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !hSyncN |-> hBlank); // R4

  AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !vSyncN |-> vBlank); // R6

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
    (hBlank || vBlank) |-> !pixel); // R10

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(screenAddr) < CELLS); // R7

endmodule

bind video_timing_gen vtg_checker #(
  .CLK_DIV(CLK_DIV), .HSYNC_CLKS(HSYNC_CLKS), .CELLS(COLS * ROWS), .AB(AB)
) uChk (
  .clk(clk), .rst(rst), .cpuClkEn(cpuClkEn), .hSyncN(hSyncN), .vSyncN(vSyncN),
  .hBlank(hBlank), .vBlank(vBlank), .screenAddr(screenAddr), .pixel(pixel)
);

// File: tb/video_timing_gen_test.sv
module video_timing_gen_test;

  localparam int LINES  = 40;
  localparam int ROWS   = 3;
  localparam int VSF    = 30;
  localparam int ACT    = ROWS * 8;
  localparam int AB     = $clog2(40 * ROWS);
  localparam int FRAME  = LINES * 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] charCode, romData;
  logic cpuClkEn, hSyncN, vSyncN, hBlank, vBlank, pixel;
  logic [AB-1:0] screenAddr;
  logic [10:0] romAddr;

  logic [7:0] ram [0:1023];
  logic [7:0] rom [0:2047];

  int unsigned t;
  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  video_timing_gen #(
    .LINES_PER_FRAME(LINES), .ROWS(ROWS), .VSYNC_FIRST(VSF)
  ) uut (
    .clk(clk), .rst(rst), .charCode(charCode), .romData(romData),
    .cpuClkEn(cpuClkEn), .hSyncN(hSyncN), .vSyncN(vSyncN),
    .hBlank(hBlank), .vBlank(vBlank), .screenAddr(screenAddr),
    .romAddr(romAddr), .pixel(pixel)
  );

  // Registered memory models: data one clock after the address
  always @(posedge clk) begin
    charCode <= ram[screenAddr];
    romData  <= rom[romAddr];
  end

  always @(posedge clk) begin
    if (rst) t <= 0;
    else     t <= t + 1;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at t=%0d", tag, act, exp, t);
    end
  endtask

  function automatic int cellAt(int ln, int col);
    return (ln / 8) * 40 + col;
  endfunction

  function automatic int patBit(int ln, int col, int b);
    logic [7:0] pat;
    pat = rom[{ram[cellAt(ln, col)], 3'(ln % 8)}];
    return int'(pat[b]);
  endfunction

  task automatic checkCycle();
    int h, ln, expAddr, ph, x;
    bit act, inFetch, inDisp;
    h  = int'(t % 1024);
    ln = int'((t / 1024) % LINES);
    act     = ln < ACT;
    inFetch = act && h >= 176 && h < 816;
    inDisp  = h >= 192 && h < 832;
    chk("R2 cpuClkEn", int'(cpuClkEn), int'(h % 16 == 0));
    chk("R3 hBlank", int'(hBlank), int'(!inDisp));
    chk("R4 hSyncN", int'(hSyncN), int'(!(h >= 880 && h < 955)));
    chk("R5 vBlank", int'(vBlank), int'(!act));
    chk("R6 vSyncN", int'(vSyncN), int'(!(ln >= VSF && ln < VSF + 3)));
    expAddr = inFetch ? cellAt(ln, (h - 176) / 16) : 0;
    chk("R7 screenAddr", int'(screenAddr), expAddr);
    ph = (h - 176) % 16;
    if (inFetch && ph >= 2)
      chk("R8 romAddr", int'(romAddr), int'({ram[expAddr], 3'(ln % 8)}));
    if (act && inDisp) begin
      x = (h - 192) / 2;
      chk("R9 pixel", int'(pixel), patBit(ln, x / 8, 7 - (x % 8)));
    end else begin
      chk("R10 pixel blank", int'(pixel), 0);
    end
  endtask

  always @(negedge clk) if (checking && !rst && !finished) checkCycle();

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic waitT(int unsigned target);
    while (t != target) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

  initial begin
    int unsigned midT;
    void'($urandom(32'd20181));
    for (int i = 0; i < 1024; i++) ram[i] = 8'($urandom);
    for (int i = 0; i < 2048; i++) rom[i] = 8'($urandom);
    midT = 1024 * $urandom_range(1, 4) + $urandom_range(0, 1023);

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 cpuClkEn", int'(cpuClkEn), 1);
    chk("R1 hBlank", int'(hBlank), 1);
    chk("R1 vBlank", int'(vBlank), 0);
    chk("R1 hSyncN", int'(hSyncN), 1);
    chk("R1 vSyncN", int'(vSyncN), 1);
    chk("R1 pixel", int'(pixel), 0);
    chk("R1 screenAddr", int'(screenAddr), 0);
    rst = 1'b0;
    checking = 1'b1;

    waitT(midT);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R11: mid-frame reset returns to line 0, clock 0
    chk("R11 vBlank", int'(vBlank), 0);
    chk("R11 hSyncN", int'(hSyncN), 1);
    chk("R11 cpuClkEn", int'(cpuClkEn), 1);
    chk("R11 screenAddr", int'(screenAddr), 0);
    rst = 1'b0;
    waitT(176 + 16 * 5);
    chk("R11 restart col5", int'(screenAddr), 5);
    waitT(8 * 1024 + 176 + 16 * 3);
    chk("R11 restart row1", int'(screenAddr), 43);

    // R5: frame boundary directed check
    waitT(FRAME - 1);
    chk("R5 last line blank", int'(vBlank), 1);
    waitT(FRAME);
    chk("R5 wrap to line 0", int'(vBlank), 0);

    waitT(2 * FRAME + 10 * 1024);
    finishRun();
  end

endmodule